// File: doc/BRIEF.md
# Flash Cycle Sequencer

This block is a memory-mapped host controller for a serial NOR flash. Software does not shift bytes one at a time. It loads a flash address, a byte count and up to sixteen 32-bit data words into a small register file. It then writes a cycle type together with a go bit. The sequencer runs the whole SPI transaction on a single-chip-select master port: the command opcode, a 24-bit address and the data phase. On a read it fills the data buffer from the flash, and it reports the outcome through sticky status flags that software clears by writing 1.

The engine supports three cycle types:
- **Read** (opcode 0x03) moves 1 to 64 bytes.
- **Program** (opcode 0x02) moves 1 to 64 bytes and is preceded by a write-enable opcode (0x06) in its own chip-select frame.
- **Block erase** (opcode 0x20) sends no data and is preceded by the same write-enable frame.

The serial clock is the system clock divided by an even parameter, in SPI mode 0. The clock idles low, data is sampled on the rising edge, and the driven line changes on the falling edge.

The register bus uses a word index. Index 0 is status, index 1 is control, index 2 is the flash address, and indices 16 to 31 are data words 0 to 15. Reads are combinational. A write takes effect at the clock edge on which `reg_wr` is high.

Top module: `spi_flash_sequencer`

## Requirements
- R1: After reset the status word reads only the erase-size field, chip select is high, the serial clock is low, and control reads zero.
- R2: The address register keeps only bits 26:0 of a write. Only bits 23:0 are sent to the flash, most significant byte first.
- R3: Byte n of a transfer lives in data word n/4 at bits 8*(n%4)+7 : 8*(n%4), i.e. little-endian. A program cycle sends its bytes in order of increasing n, each byte most significant bit first.
- R4: A read is started by writing control with type 0 (bits 2:1), go (bit 0) and count (bits 13:8). It sends one frame containing 0x03, the address, and count+1 dummy 0x00 bytes. The bytes sampled from the flash during the dummy bytes are stored into the buffer. Buffer lanes beyond the transfer are left unchanged.
- R5: Type 2 (program) sends 0x06 alone in one frame, then a second frame containing 0x02, the address and count+1 data bytes.
- R6: Type 3 (erase) sends a 0x06 frame, then a frame containing 0x20 and the address. The count field has no effect on this cycle.
- R7: Status bit 5 (in progress) reads 1 in the cycle after the go write. It drops in the same cycle that chip select rises at the end of the cycle. At that moment status bit 0 (done) becomes 1 and control bit 0 (go) reads back 0.
- R8: A go written while a cycle is in progress is discarded: the running cycle finishes unchanged and the stored type and count are kept. Status bit 2 (access error log) is set.
- R9: Status bits 0, 1 and 2 are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R10: Type 1 with go does not start a cycle and produces no serial activity. It sets status bit 1 (cycle error) in the next cycle.
- R11: Status bits 4:3 report the erase block size (00 = 256 B, 01 = 4 KB, 10 = 8 KB, 11 = 64 KB) from a parameter. Writes do not change them.
- R12: Status bit 15 (lock-down) is set by writing 1. It stays set until reset.
- R13: Inside a frame, consecutive rising edges of the serial clock are SCK_DIV system clocks apart. The serial clock is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Byte-count edges.** A one-byte read and a full 64-byte read are both run. An off-by-one in the count+1 rule would show up as one byte too many or too few on the wire.
- **Partial final word.** A five-byte read checks that only lane 0 of word 1 is overwritten. A wrong lane mapping would corrupt neighbouring bytes.
- **Separate write-enable frame.** A program and an erase must each show the write-enable in its own chip-select frame. The erase is run with a large count field, so a design that honoured the count on erase would emit extra bytes.
- **Go while busy.** A go is written during a running read. A design that accepted it would put foreign bytes on the wire or change the stored type.
- **Reserved type.** The reserved cycle type is issued. A design that started a cycle anyway would emit unexpected serial traffic.
- **Sticky flags.** The write-1-to-clear flags and the lock bit are written with 0 and then with 1. A plain read-write implementation would lose the flags on the 0 write.

// File: rtl/spi_flash_sequencer.sv
module spi_flash_sequencer #(
  parameter int         SCK_DIV    = 4,
  parameter logic [1:0] ERASE_SIZE = 2'b01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  localparam int HALF = SCK_DIV / 2;
  localparam int CW   = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1;
  localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);
  localparam logic [CW-1:0] GAP_END  = CW'(SCK_DIV - 1);

  localparam logic [4:0] A_STAT = 5'd0;
  localparam logic [4:0] A_CTRL = 5'd1;
  localparam logic [4:0] A_ADDR = 5'd2;

  localparam logic [1:0] T_READ  = 2'd0;
  localparam logic [1:0] T_RSVD  = 2'd1;
  localparam logic [1:0] T_WRITE = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_WEN, S_GAP, S_XFER} st_t;

  st_t          st;
  logic         done_f, err_f, ael_f, lock_f;
  logic [1:0]   typ_q;
  logic [5:0]   cnt_q;
  logic [26:0]  addr_q;
  logic [31:0]  buf_q [16];
  logic         sck_q, cs_q;
  logic [7:0]   sh_q, in_q;
  logic [2:0]   bit_q;
  logic [6:0]   byte_q;
  logic [CW-1:0] div_q;

  wire busy    = (st != S_IDLE);
  wire wr_stat = reg_wr && (reg_addr == A_STAT);
  wire wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  wire wr_addr = reg_wr && (reg_addr == A_ADDR);
  wire wr_data = reg_wr && reg_addr[4];
  wire [1:0] w_typ = reg_wdata[2:1];

  wire [6:0] last_idx = (typ_q == T_READ || typ_q == T_WRITE) ? 7'd4 + {1'b0, cnt_q} : 7'd3;
  wire [6:0] nb       = byte_q + 7'd1;
  wire [5:0] bi       = nb[5:0] - 6'd4;
  wire [5:0] ci       = byte_q[5:0] - 6'd4;

  logic [7:0] nbyte;
  always_comb begin
    case (nb)
      7'd1:    nbyte = addr_q[23:16];
      7'd2:    nbyte = addr_q[15:8];
      7'd3:    nbyte = addr_q[7:0];
      default: nbyte = (typ_q == T_WRITE) ? buf_q[bi[5:2]][{bi[1:0], 3'b000} +: 8] : 8'h00;
    endcase
  end

  assign spi_sck  = sck_q;
  assign spi_cs_n = cs_q;
  assign spi_mosi = cs_q ? 1'b0 : sh_q[7];

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = {16'h0, lock_f, 9'h0, busy, ERASE_SIZE, ael_f, err_f, done_f};
      A_CTRL:  reg_rdata = {18'h0, cnt_q, 5'h0, typ_q, busy};
      A_ADDR:  reg_rdata = {5'h0, addr_q};
      default: reg_rdata = reg_addr[4] ? buf_q[reg_addr[3:0]] : 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done_f <= 1'b0;
      err_f  <= 1'b0;
      ael_f  <= 1'b0;
      lock_f <= 1'b0;
      typ_q  <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
      for (int i = 0; i < 16; i++) buf_q[i] <= '0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      sh_q   <= '0;
      in_q   <= '0;
      bit_q  <= '0;
      byte_q <= '0;
      div_q  <= '0;
    end else begin
      if (wr_stat) begin
        done_f <= done_f & ~reg_wdata[0];
        err_f  <= err_f  & ~reg_wdata[1];
        ael_f  <= ael_f  & ~reg_wdata[2];
        lock_f <= lock_f |  reg_wdata[15];
      end
      if (wr_addr && !busy) addr_q <= reg_wdata[26:0];
      if (wr_data && !busy) buf_q[reg_addr[3:0]] <= reg_wdata;
      if (wr_ctrl) begin
        if (busy) begin
          if (reg_wdata[0]) ael_f <= 1'b1;
        end else begin
          typ_q <= w_typ;
          cnt_q <= reg_wdata[13:8];
          if (reg_wdata[0]) begin
            if (w_typ == T_RSVD) begin
              err_f <= 1'b1;
            end else begin
              st     <= (w_typ == T_READ) ? S_XFER : S_WEN;
              sh_q   <= (w_typ == T_READ) ? 8'h03 : 8'h06;
              cs_q   <= 1'b0;
              sck_q  <= 1'b0;
              bit_q  <= '0;
              byte_q <= '0;
              div_q  <= '0;
            end
          end
        end
      end

      case (st)
        S_WEN, S_XFER: begin
          if (div_q == HALF_END) begin
            div_q <= '0;
            sck_q <= ~sck_q;
            if (!sck_q) begin
              in_q <= {in_q[6:0], spi_miso};
            end else if (bit_q != 3'd7) begin
              sh_q  <= {sh_q[6:0], 1'b0};
              bit_q <= bit_q + 3'd1;
            end else begin
              bit_q <= '0;
              if (st == S_WEN) begin
                cs_q <= 1'b1;
                st   <= S_GAP;
              end else begin
                if (typ_q == T_READ && byte_q >= 7'd4)
                  buf_q[ci[5:2]][{ci[1:0], 3'b000} +: 8] <= in_q;
                if (byte_q == last_idx) begin
                  cs_q   <= 1'b1;
                  st     <= S_IDLE;
                  done_f <= 1'b1;
                end else begin
                  byte_q <= nb;
                  sh_q   <= nbyte;
                end
              end
            end
          end else begin
            div_q <= div_q + CW'(1);
          end
        end
        S_GAP: begin
          if (div_q == GAP_END) begin
            div_q  <= '0;
            cs_q   <= 1'b0;
            st     <= S_XFER;
            byte_q <= '0;
            sh_q   <= (typ_q == T_WRITE) ? 8'h02 : 8'h20;
          end else begin
            div_q <= div_q + CW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  a_r7_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);

  a_r13_sck_low_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  a_r7_done_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done_f && $rose(spi_cs_n)));

  a_r8_go_busy_logged: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl && reg_wdata[0]) |=> ael_f);

  a_r10_reserved_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_ctrl && reg_wdata[0] && w_typ == T_RSVD) |=> (!busy && err_f && spi_cs_n));

  a_r12_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_f |=> lock_f);

endmodule

// File: tb/tb_spi_flash_sequencer.sv
module tb_spi_flash_sequencer;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SCK_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  logic [8:0] exp_q [$];
  logic [31:0] shadow [16];

  int   mon_bits = 0;
  logic [7:0] mon_op = 8'h00;

  spi_flash_sequencer #(.SCK_DIV(SCK_DIV), .ERASE_SIZE(2'b01)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #5 clk = ~clk;

  function automatic logic [7:0] flash_byte(input int j);
    return 8'((j * 29) ^ 8'h5A);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic push_frame_hdr(input logic [7:0] op, input logic [26:0] a);
    exp_q.push_back({1'b1, op});
    exp_q.push_back({1'b0, a[23:16]});
    exp_q.push_back({1'b0, a[15:8]});
    exp_q.push_back({1'b0, a[7:0]});
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    int n;
    rd(5'd0, s);
    check({req, " R7 busy after go"}, {31'h0, s[5]}, 32'h1);
    n = 0;
    while (s[5] && n < 5000) begin
      @(negedge clk);
      rd(5'd0, s);
      n++;
    end
    check({req, " R7 done at end"}, {30'h0, s[5], s[0]}, 32'h1);
    check({req, " R7 cs high at end"}, {31'h0, spi_cs_n}, 32'h1);
    rd(5'd1, s);
    check({req, " R7 go self-clear"}, {31'h0, s[0]}, 32'h0);
    check({req, " scoreboard drained"}, exp_q.size(), 32'h0);
    wr(5'd0, 32'h7);
  endtask

  task automatic do_read(input logic [26:0] a, input int n);
    logic [31:0] d;
    for (int i = 0; i < 16; i++) begin
      shadow[i] = 32'hC0C0_C000 | 32'(i);
      wr(5'(16 + i), shadow[i]);
    end
    push_frame_hdr(8'h03, a);
    for (int j = 0; j < n; j++) begin
      exp_q.push_back({1'b0, 8'h00});
      shadow[j / 4][8 * (j % 4) +: 8] = flash_byte(j);
    end
    wr(5'd2, {5'h0, a});
    wr(5'd1, 32'((n - 1) << 8) | 32'h1);
    wait_done("R4 read");
    for (int i = 0; i < 16; i++) begin
      rd(5'(16 + i), d);
      check("R4 R3 read buffer word", d, shadow[i]);
    end
  endtask

  always @(negedge spi_sck) begin
    if (!spi_cs_n && mon_op == 8'h03 && mon_bits >= 32)
      spi_miso = flash_byte((mon_bits - 32) / 8)[7 - (mon_bits % 8)];
  end

  initial begin
    logic [7:0] sh;
    logic       first;
    logic [8:0] e;
    time        tp;
    logic       havep;
    forever begin
      @(negedge spi_cs_n);
      mon_bits = 0; first = 1'b1; havep = 1'b0; sh = '0; mon_op = 8'h00;
      forever begin
        @(posedge spi_sck or posedge spi_cs_n);
        if (spi_cs_n) break;
        if (havep) check("R13 sck period", 32'($time - tp), 32'(SCK_DIV * 10));
        tp = $time; havep = 1'b1;
        sh = {sh[6:0], spi_mosi};
        mon_bits++;
        if (mon_bits % 8 == 0) begin
          if (mon_bits == 8) mon_op = sh;
          if (exp_q.size() == 0) begin
            check("R10 R6 unexpected serial byte", {23'h0, first, sh}, 32'h1FF);
          end else begin
            e = exp_q.pop_front();
            check("R3 R4 R5 R6 serial byte", {23'h0, first, sh}, {23'h0, e});
          end
          first = 1'b0;
        end
      end
      check("R13 whole bytes per frame", 32'(mon_bits % 8), 32'h0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(5'd0, d); check("R1 reset status", d, 32'h0000_0008);
    rd(5'd1, d); check("R1 reset control", d, 32'h0);
    check("R1 reset pins", {30'h0, spi_cs_n, spi_sck}, 32'h2);

    wr(5'd2, 32'hFFFF_FFFF);
    rd(5'd2, d); check("R2 address mask", d, 32'h07FF_FFFF);

    do_read(27'h5ABCDEF, 1);
    do_read(27'h0012345, 5);
    do_read(27'h0000100, 64);

    wr(5'd16, 32'h4433_2211);
    wr(5'd17, 32'h0077_6655);
    rd(5'd17, d); check("R3 buffer write readback", d, 32'h0077_6655);
    exp_q.push_back({1'b1, 8'h06});
    push_frame_hdr(8'h02, 27'h0A0B0C);
    for (int j = 0; j < 7; j++) exp_q.push_back({1'b0, 8'(8'h11 * (j + 1))});
    wr(5'd2, 32'h000A_0B0C);
    wr(5'd1, 32'h0000_0605);
    wait_done("R5 program");

    exp_q.push_back({1'b1, 8'h06});
    push_frame_hdr(8'h20, 27'h7F000);
    wr(5'd2, 32'h0007_F000);
    wr(5'd1, 32'h0000_3F07);
    wait_done("R6 erase");
    rd(5'd1, d); check("R6 erase control readback", d, 32'h0000_3F06);

    push_frame_hdr(8'h03, 27'h001000);
    for (int j = 0; j < 4; j++) exp_q.push_back({1'b0, 8'h00});
    wr(5'd2, 32'h0000_1000);
    wr(5'd1, 32'h0000_0301);
    wr(5'd1, 32'h0000_0007);
    rd(5'd0, d); check("R8 ael set on go while busy", {31'h0, d[2]}, 32'h1);
    rd(5'd1, d); check("R8 stored command kept", d & 32'h3F06, 32'h0000_0300);
    wait_done("R8 read");

    wr(5'd1, 32'h0000_0003);
    rd(5'd0, d); check("R10 reserved type error", d & 32'h23, 32'h2);
    repeat (40) @(negedge clk);
    check("R10 no serial activity", {31'h0, spi_cs_n}, 32'h1);

    wr(5'd0, 32'h0);
    rd(5'd0, d); check("R9 zero write keeps flag", {31'h0, d[1]}, 32'h1);
    wr(5'd0, 32'h2);
    rd(5'd0, d); check("R9 one write clears flag", {31'h0, d[1]}, 32'h0);

    wr(5'd0, 32'h0000_0018);
    rd(5'd0, d); check("R11 erase size read-only", {30'h0, d[4:3]}, 32'h1);

    wr(5'd0, 32'h0000_8000);
    wr(5'd0, 32'h0);
    rd(5'd0, d); check("R12 lock sticky", {31'h0, d[15]}, 32'h1);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule